// File: doc/BRIEF.md
# Ternary SAR conversion controller

This block sequences a successive-approximation converter whose quantizer returns three outcomes per cycle. In each conversion cycle an external comparator reports a polarity bit and a flag that says the decision came too late, that is, after a delay reference expired. A late decision means the residue is small, so the stage digit is zero and no capacitor is switched. A timely decision gives a digit of +1 or -1, and the controller switches that stage's capacitor to subtract or to add the stage weight.

The stages are arranged in groups that share one delay reference. Once a group yields a zero digit, the residue stays unchanged and the reference stays the same. Every later stage in that group would also return zero, so the controller marks them as zero without firing the comparator and jumps to the first stage of the next group. Small inputs therefore finish in fewer cycles than there are stages. The digits overlap in the same way as a 1.5-bit-per-stage pipeline: each digit is added with weight 2^(N-1-i). That redundancy lets later stages correct an early over-range decision without any extra cycle.

A start strobe opens one sampling cycle, then the comparison cycles follow. A one-cycle valid pulse presents the saturated result word.

Top module: `tsar_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all DAC controls are in the common-mode position (`dac_sub` and `dac_add` all zero), and `valid`, `cmp_fire` and `ref_sel` are low.
- R2: In a fired cycle, `cmp_slow`=1 gives digit 0 and leaves every DAC control unchanged. Otherwise `cmp_pos`=1 gives +1 and sets `dac_sub[i]`, and `cmp_pos`=0 gives -1 and sets `dac_add[i]`, where bit i belongs to stage i and stage 0 is the most significant stage.
- R3: A zero digit in a stage also sets the remaining stages of its group (GROUP_SIZE consecutive stages) to zero without firing. The next comparison is the first stage of the following group, or the conversion ends if no group follows.
- R4: `ref_sel` is one-hot with bit g set, g being the group of the stage under comparison, in exactly the cycles where `cmp_fire` is high. It is all zero otherwise.
- R5: `result` is the sum of digit_i times 2^(N-1-i), saturated to an N-bit two's-complement value.
- R6: `valid` is high for exactly one cycle per conversion, and that cycle directly follows the last fired cycle.
- R7: A start strobe that arrives while a conversion is under way (sampling, comparing or finishing) is ignored.
- R8: If start is seen high at a clock edge while idle, the next cycle is the sampling cycle with `cmp_fire` low, and the cycle after that is the first comparison.
- R9: Accepting a start returns all DAC controls to common mode before the sampling cycle. The DAC controls and `result` then hold their final values after `valid` until the next start is accepted.
- R10: Take an ideal comparator whose late band for group g is |residue| below half the weight of that group's last stage. For any integer input within ±(2^N-1) LSB, the final DAC residue is zero and the digit sum equals the input exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample/start strobe, acted on only while idle |
| cmp_pos | input | 1 | Comparator polarity: 1 when the residue is positive |
| cmp_slow | input | 1 | 1 when the decision came after the delay reference expired |
| cmp_fire | output | 1 | Comparator clock enable for the current stage |
| ref_sel | output | N_STAGES/GROUP_SIZE | One-hot delay-reference select for the active group |
| dac_sub | output | N_STAGES | Per-stage control: switch capacitor to subtract its weight |
| dac_add | output | N_STAGES | Per-stage control: switch capacitor to add its weight |
| valid | output | 1 | One-cycle pulse marking a finished result |
| result | output | N_STAGES | Saturated two's-complement conversion word |

## Verification
The assertions assume that `cmp_pos` and `cmp_slow` have settled before each clock edge at which `cmp_fire` is high, and that `start` changes synchronously with `clk`. The bench meets both conditions. Its comparator model is combinational and computes the residue from the DAC controls and `ref_sel`, and all inputs are driven on the falling edge. The exact-conversion checks use only inputs inside ±(2^N-1) LSB. Larger codes are reached through the saturation cases at ±255 and at 200 and -129.

// File: rtl/tsar_pkg.sv
package tsar_pkg;

    // Ternary stage digit, two bits per stage
    typedef enum logic [1:0] {
        DIG_MID = 2'b00,
        DIG_POS = 2'b01,
        DIG_NEG = 2'b11
    } digit_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_SAMPLE  = 2'b01,
        ST_CONVERT = 2'b10,
        ST_DONE    = 2'b11
    } state_t;

endpackage

// File: rtl/tsar_digit_decode.sv
module tsar_digit_decode
    import tsar_pkg::*;
(
    input  logic   cmp_pos,
    input  logic   cmp_slow,
    output digit_t digit
);
    // A late decision marks a small residue: middle code
    always_comb begin
        if (cmp_slow)
            digit = DIG_MID;
        else if (cmp_pos)
            digit = DIG_POS;
        else
            digit = DIG_NEG;
    end
endmodule

// File: rtl/tsar_stage_ring.sv
module tsar_stage_ring #(
    parameter int N_STAGES   = 8,
    parameter int GROUP_SIZE = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic                  skip,
    output logic [N_STAGES-1:0]   ring_q,
    output logic [N_STAGES/GROUP_SIZE-1:0] grp_sel,
    output logic                  last
);
    localparam int N_GROUPS = N_STAGES / GROUP_SIZE;

    logic [N_STAGES-1:0] ring_d;

    // Next one-hot position: plain advance, or jump to next group head
    generate
        for (genvar j = 0; j < N_STAGES; j++) begin : g_next
            if (j == 0) begin : g_head0
                assign ring_d[j] = load;
            end else if ((j % GROUP_SIZE) == 0) begin : g_head
                assign ring_d[j] = step & (skip ? (|ring_q[j-GROUP_SIZE +: GROUP_SIZE])
                                                : ring_q[j-1]);
            end else begin : g_body
                assign ring_d[j] = step & ~skip & ring_q[j-1];
            end
        end
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
            assign grp_sel[g] = |ring_q[g*GROUP_SIZE +: GROUP_SIZE];
        end
    endgenerate

    assign last = step & (ring_d == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ring_q <= '0;
        else if (load || step)
            ring_q <= ring_d;
    end

    // R3: ring never holds more than one stage
    a_r3_ring_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring_q));

    // R3: a middle code moves the pointer to the head of the next group
    a_r3_skip_next_group: assert property (@(posedge clk) disable iff (!rst_n)
        (step && skip) |=> (grp_sel == ($past(grp_sel) << 1)));
endmodule

// File: rtl/tsar_accum.sv
module tsar_accum
    import tsar_pkg::*;
#(
    parameter int N_STAGES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                add_en,
    input  digit_t              digit,
    input  logic [N_STAGES-1:0] ring_q,
    output logic [N_STAGES-1:0] result
);
    localparam int AW = N_STAGES + 2;
    localparam logic signed [AW-1:0] MAX_V = (AW'(1) <<< (N_STAGES-1)) - AW'(1);
    localparam logic signed [AW-1:0] MIN_V = -(AW'(1) <<< (N_STAGES-1));
    localparam logic signed [AW-1:0] FULL  = (AW'(1) <<< N_STAGES) - AW'(1);

    logic [N_STAGES-1:0]    weight;
    logic signed [AW-1:0]   wext;
    logic signed [AW-1:0]   acc_q;

    // Stage i carries weight 2^(N-1-i): bit-reverse the one-hot pointer
    generate
        for (genvar i = 0; i < N_STAGES; i++) begin : g_rev
            assign weight[N_STAGES-1-i] = ring_q[i];
        end
    endgenerate

    assign wext = {2'b00, weight};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (add_en) begin
            unique case (digit)
                DIG_POS: acc_q <= acc_q + wext;
                DIG_NEG: acc_q <= acc_q - wext;
                default: acc_q <= acc_q;
            endcase
        end
    end

    always_comb begin
        if (acc_q > MAX_V)
            result = MAX_V[N_STAGES-1:0];
        else if (acc_q < MIN_V)
            result = MIN_V[N_STAGES-1:0];
        else
            result = acc_q[N_STAGES-1:0];
    end

    // R5: the overlapped sum stays within the range the stages can reach
    a_r5_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q <= FULL) && (acc_q >= -FULL));
endmodule

// File: rtl/tsar_ctrl.sv
module tsar_ctrl
    import tsar_pkg::*;
#(
    parameter int N_STAGES   = 8,
    parameter int GROUP_SIZE = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             cmp_pos,
    input  logic                             cmp_slow,
    output logic                             cmp_fire,
    output logic [N_STAGES/GROUP_SIZE-1:0]   ref_sel,
    output logic [N_STAGES-1:0]              dac_sub,
    output logic [N_STAGES-1:0]              dac_add,
    output logic                             valid,
    output logic [N_STAGES-1:0]              result
);
    localparam int N_GROUPS = N_STAGES / GROUP_SIZE;

    state_t                 state_q, state_d;
    digit_t                 digit;
    logic [N_STAGES-1:0]    ring_q;
    logic [N_GROUPS-1:0]    grp_sel;
    logic                   conv_end;
    logic                   ring_load, ring_step, ring_skip, accept;

    tsar_digit_decode u_dec (
        .cmp_pos  (cmp_pos),
        .cmp_slow (cmp_slow),
        .digit    (digit)
    );

    tsar_stage_ring #(.N_STAGES(N_STAGES), .GROUP_SIZE(GROUP_SIZE)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ring_load),
        .step    (ring_step),
        .skip    (ring_skip),
        .ring_q  (ring_q),
        .grp_sel (grp_sel),
        .last    (conv_end)
    );

    tsar_accum #(.N_STAGES(N_STAGES)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .add_en (ring_step),
        .digit  (digit),
        .ring_q (ring_q),
        .result (result)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SAMPLE;
            ST_SAMPLE:  state_d = ST_CONVERT;
            ST_CONVERT: if (conv_end) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        accept    = (state_q == ST_IDLE) && start;
        ring_load = (state_q == ST_SAMPLE);
        cmp_fire  = (state_q == ST_CONVERT);
        ring_step = cmp_fire;
        ring_skip = cmp_fire && (digit == DIG_MID);
        valid     = (state_q == ST_DONE);
        ref_sel   = cmp_fire ? grp_sel : '0;
    end

    // DAC switch controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_sub <= '0;
            dac_add <= '0;
        end else if (accept) begin
            dac_sub <= '0;
            dac_add <= '0;
        end else if (cmp_fire) begin
            if (digit == DIG_POS)
                dac_sub <= dac_sub | ring_q;
            else if (digit == DIG_NEG)
                dac_add <= dac_add | ring_q;
        end
    end

    // R2: a stage never drives both switch directions
    a_r2_dac_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sub & dac_add) == '0);

    // R2: a late decision leaves the capacitor array untouched
    a_r2_mid_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fire && cmp_slow) |=> ($stable(dac_sub) && $stable(dac_add)));

    // R4: exactly one reference selected while comparing
    a_r4_ref_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire |-> ($countones(ref_sel) == 1));

    a_r4_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_fire |-> (ref_sel == '0));

    // R6: valid is a single-cycle pulse right after the last comparison
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r6_valid_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(cmp_fire));

    // R7: start outside idle never restarts sampling
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_SAMPLE));

    // R8: the sampling cycle is followed by the first comparison
    a_r8_sample_then_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |=> cmp_fire);

    // R9: DAC is at common mode during sampling
    a_r9_dac_clear_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |-> (dac_sub == '0 && dac_add == '0));
endmodule

// File: tb/tsar_ctrl_tb_top.sv
module tsar_ctrl_tb_top;
    localparam int N  = 8;
    localparam int GS = 2;
    localparam int NG = N / GS;
    localparam int NV = 10;

    // input, expected result, expected comparator firings
    localparam int VIN[NV]   = '{0, 255, -255, 100, 5, -40, 127, -128, 200, -129};
    localparam int EXP_R[NV] = '{0, 127, -128, 100, 5, -40, 127, -128, 127, -128};
    localparam int EXP_F[NV] = '{4, 8, 8, 7, 6, 7, 6, 5, 7, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_pos, cmp_slow, cmp_fire, valid;
    logic [NG-1:0] ref_sel;
    logic [N-1:0] dac_sub, dac_add, result;

    int vin = 0;
    int resid;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tsar_ctrl #(.N_STAGES(N), .GROUP_SIZE(GS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmp_pos(cmp_pos), .cmp_slow(cmp_slow), .cmp_fire(cmp_fire),
        .ref_sel(ref_sel), .dac_sub(dac_sub), .dac_add(dac_add),
        .valid(valid), .result(result)
    );

    // Ideal comparator: residue from DAC, late band from the selected group
    always_comb begin
        int r;
        int wl;
        r = vin;
        for (int i = 0; i < N; i++) begin
            if (dac_sub[i]) r = r - (1 << (N-1-i));
            if (dac_add[i]) r = r + (1 << (N-1-i));
        end
        resid = r;
        wl = 0;
        for (int g = 0; g < NG; g++)
            if (ref_sel[g]) wl = 1 << (N-1-(g*GS+GS-1));
        cmp_pos  = (r > 0);
        cmp_slow = (wl != 0) && ((2 * (r < 0 ? -r : r)) < wl);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int v, input bit poke,
                           output int res, output int fires, output int first_at,
                           output int valids, output int rsd, output int samp_dac,
                           output logic [N-1:0] sub, output logic [N-1:0] add);
        vin = v;
        fires = 0; valids = 0; first_at = -1; res = 0; rsd = 0; samp_dac = -1;
        sub = '0; add = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int n = 1; n <= 30; n++) begin
            if (n == 1) samp_dac = int'(dac_sub | dac_add);
            if (cmp_fire) begin
                fires++;
                if (first_at < 0) first_at = n;
            end
            if (valid) begin
                valids++;
                res = int'($signed(result));
                rsd = resid;
                sub = dac_sub;
                add = dac_add;
            end
            start = (poke && (n == 3 || n == 4));
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        int res, fires, first_at, valids, rsd, sd;
        logic [N-1:0] sub, add;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(dac_sub == '0 && dac_add == '0, "R1 dac reset", int'(dac_sub | dac_add), 0);
        check(!valid && !cmp_fire && ref_sel == '0, "R1 outputs reset", int'(valid) + int'(cmp_fire), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid && !cmp_fire, "R1 after release", int'(valid), 0);

        // Vector table: R5 result, R3 firing count, R6 pulse, R8 latency, R10 residue
        for (int k = 0; k < NV; k++) begin
            convert(VIN[k], 1'b0, res, fires, first_at, valids, rsd, sd, sub, add);
            check(res == EXP_R[k], "R5 result", res, EXP_R[k]);
            check(fires == EXP_F[k], "R3 firings", fires, EXP_F[k]);
            check(valids == 1, "R6 valid count", valids, 1);
            check(first_at == 2, "R8 first fire", first_at, 2);
            check(rsd == 0, "R10 residue", rsd, 0);
            check(sd == 0, "R9 dac cleared at sample", sd, 0);
            check(dac_sub == sub && dac_add == add, "R9 dac hold", int'(dac_sub), int'(sub));
        end

        // R2: DAC pattern for +100 (stages 0,4 subtract; 2,5 add)
        convert(100, 1'b0, res, fires, first_at, valids, rsd, sd, sub, add);
        check(sub == 8'h11, "R2 dac_sub pattern", int'(sub), 8'h11);
        check(add == 8'h24, "R2 dac_add pattern", int'(add), 8'h24);

        // R2: all-middle conversion switches nothing
        convert(0, 1'b0, res, fires, first_at, valids, rsd, sd, sub, add);
        check(sub == '0 && add == '0, "R2 middle no switch", int'(sub | add), 0);

        // R7: start pulses during conversion are ignored
        convert(-40, 1'b1, res, fires, first_at, valids, rsd, sd, sub, add);
        check(valids == 1, "R7 single valid", valids, 1);
        check(fires == 7, "R7 firings unchanged", fires, 7);
        check(res == -40, "R7 result unchanged", res, -40);

        // R1: reset in mid-conversion returns DAC to common mode
        vin = 255;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(dac_sub == '0 && dac_add == '0, "R1 mid reset dac", int'(dac_sub | dac_add), 0);
        check(!valid && !cmp_fire, "R1 mid reset ctrl", int'(cmp_fire), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        convert(-129, 1'b0, res, fires, first_at, valids, rsd, sd, sub, add);
        check(res == -128, "R5 after reset", res, -128);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule